// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receiver. Each time the receiver finishes assembling a frame, it presents the frame for one cycle: four identifier bytes, a length code and the payload. The block stores every such frame in a background buffer without condition. On the next cycle it compares the stored identifier bit by bit against eight programmable bytes. Four of these bytes are acceptance values and four are masks. A frame that passes is copied to a foreground buffer that the CPU can see, and a receive-full flag and interrupt are raised. A frame that fails is dropped: it stays in the background buffer until the next frame overwrites it.

The number of identifier bytes compared depends on the frame format. An extended frame is compared over all four bytes. A standard frame is compared over bytes 0 and 1 only. Software must set the three low mask bits of byte 1 to don't care for standard frames, because those bit positions do not carry identifier bits. The CPU releases the foreground buffer with a one-cycle pulse. An accepted frame that arrives while the buffer is still held is reported as an overrun.

Top module: `can_id_filter`

## Requirements
- R1: A frame presented with `frm_valid` high at a clock edge appears on `bg_id` after that edge, whether it is later accepted or not, and replaces the previous background frame.
- R2: The filter registers sit at `reg_addr` 0..3 (acceptance bytes 0..3) and 4..7 (mask bytes 0..3). A mask bit of 1 makes its position don't care. A mask bit of 0 requires the identifier bit to equal the acceptance bit. Identifier byte 0 is `frm_id[31:24]` and byte 3 is `frm_id[7:0]`.
- R3: When bit 3 of identifier byte 1 (`frm_id[19]`) is 1, the frame is extended, and all four bytes must match for the frame to be accepted.
- R4: When `frm_id[19]` is 0, the frame is standard. Only bytes 0 and 1 are compared, and acceptance and mask bytes 2 and 3 have no effect.
- R5: An accepted frame is copied to `fg_id`, `fg_len` and `fg_data` on the edge after its capture edge. At that edge `rx_full` and `rx_irq` go high.
- R6: A rejected frame leaves the foreground buffer, `rx_full` and `overrun` unchanged.
- R7: `rx_full` stays set until `cpu_release` is sampled high. If a release and an acceptance fall on the same edge, the new frame is copied and `rx_full` stays set.
- R8: A frame accepted while `rx_full` is set and not being released leaves the foreground buffer unchanged and sets `overrun`. `overrun` stays set until `ovr_clr`, and a new overrun on the same edge as `ovr_clr` takes priority.
- R9: After reset, all eight filter bytes read as zero, and `rx_full` and `overrun` are low. Written bytes read back on `reg_rdata` in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Filter register write strobe |
| reg_addr | input | 3 | Filter register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| frm_valid | input | 1 | Frame complete, one-cycle pulse |
| frm_id | input | 32 | Identifier bytes 0..3, byte 0 in the top bits |
| frm_len | input | LW | Payload length code |
| frm_data | input | 8*DATA_BYTES | Payload |
| bg_id | output | 32 | Identifier held in the background buffer |
| fg_id | output | 32 | Foreground identifier |
| fg_len | output | LW | Foreground length |
| fg_data | output | 8*DATA_BYTES | Foreground payload |
| rx_full | output | 1 | Foreground buffer holds an unread frame |
| rx_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky overrun flag |
| cpu_release | input | 1 | Releases the foreground buffer |
| ovr_clr | input | 1 | Clears `overrun` |

## Verification
Four properties are checked on every cycle:
- a new frame always lands in the background buffer;
- the foreground buffer holds still while full and not released;
- every rising edge of `rx_full` carries the background identifier of the cycle before;
- `overrun` can only rise while the buffer is full, and a clear while the buffer is empty always leaves it low.

Whether a given identifier is accepted, and how the comparison width follows the format bit, can only be shown by the bench scenarios. The bench compares random identifiers near the programmed acceptance value with a reference model. Directed cases cover a single-bit miss in byte 3, masked don't-care bits, standard frames with bytes 2 and 3 ignored, and a release on the same edge as an acceptance.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int DATA_BYTES = 8,
  localparam int DW = 8 * DATA_BYTES,
  localparam int LW = $clog2(DATA_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          frm_valid,
  input  logic [31:0]   frm_id,
  input  logic [LW-1:0] frm_len,
  input  logic [DW-1:0] frm_data,
  output logic [31:0]   bg_id,
  output logic [31:0]   fg_id,
  output logic [LW-1:0] fg_len,
  output logic [DW-1:0] fg_data,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          overrun,
  input  logic          cpu_release,
  input  logic          ovr_clr
);
  localparam int IDE_BIT = 19;

  logic [7:0]    acc_q [4];
  logic [7:0]    msk_q [4];
  logic [LW-1:0] bg_len;
  logic [DW-1:0] bg_data;
  logic          pend_q;
  logic [31:0]   acc_w, msk_w, miss;
  logic          hit, take, can_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        acc_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr[2]) msk_q[reg_addr[1:0]] <= reg_wdata;
      else             acc_q[reg_addr[1:0]] <= reg_wdata;
    end
  end

  assign reg_rdata = reg_addr[2] ? msk_q[reg_addr[1:0]] : acc_q[reg_addr[1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_id   <= '0;
      bg_len  <= '0;
      bg_data <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= frm_valid;
      if (frm_valid) begin
        bg_id   <= frm_id;
        bg_len  <= frm_len;
        bg_data <= frm_data;
      end
    end
  end

  assign acc_w    = {acc_q[0], acc_q[1], acc_q[2], acc_q[3]};
  assign msk_w    = {msk_q[0], msk_q[1], msk_q[2], msk_q[3]};
  assign miss     = (bg_id ^ acc_w) & ~msk_w;
  assign hit      = bg_id[IDE_BIT] ? (miss == '0) : (miss[31:16] == '0);
  assign take     = pend_q && hit;
  assign can_load = !rx_full || cpu_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_id   <= '0;
      fg_len  <= '0;
      fg_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (take && can_load) begin
        fg_id   <= bg_id;
        fg_len  <= bg_len;
        fg_data <= bg_data;
        rx_full <= 1'b1;
      end else if (cpu_release) begin
        rx_full <= 1'b0;
      end
      if (take && !can_load) overrun <= 1'b1;
      else if (ovr_clr)      overrun <= 1'b0;
    end
  end

  assign rx_irq = rx_full;
endmodule

module can_id_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frm_valid,
  input logic [31:0] frm_id,
  input logic [31:0] bg_id,
  input logic [31:0] fg_id,
  input logic        rx_full,
  input logic        overrun,
  input logic        cpu_release,
  input logic        ovr_clr
);
  // R1
  bg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> bg_id == $past(frm_id));
  // R7
  fg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !cpu_release |=> $stable(fg_id));
  // R5
  fg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> fg_id == $past(bg_id));
  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full));
  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !rx_full |=> !overrun);
endmodule

bind can_id_filter can_id_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
  .bg_id(bg_id), .fg_id(fg_id), .rx_full(rx_full), .overrun(overrun),
  .cpu_release(cpu_release), .ovr_clr(ovr_clr)
);

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;
  localparam int DB = 8;
  localparam int DW = 8 * DB;
  localparam int LW = $clog2(DB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          frm_valid = 1'b0;
  logic [31:0]   frm_id = '0;
  logic [LW-1:0] frm_len = '0;
  logic [DW-1:0] frm_data = '0;
  logic [31:0]   bg_id, fg_id;
  logic [LW-1:0] fg_len;
  logic [DW-1:0] fg_data;
  logic          rx_full, rx_irq, overrun;
  logic          cpu_release = 1'b0;
  logic          ovr_clr = 1'b0;

  can_id_filter #(.DATA_BYTES(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_valid(frm_valid),
    .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data), .bg_id(bg_id),
    .fg_id(fg_id), .fg_len(fg_len), .fg_data(fg_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .overrun(overrun), .cpu_release(cpu_release),
    .ovr_clr(ovr_clr)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0]    m_acc [4];
  logic [7:0]    m_msk [4];
  logic [31:0]   e_fg = '0;
  logic [LW-1:0] e_len = '0;
  logic [DW-1:0] e_data = '0;
  bit            e_full = 0;
  bit            e_ovr = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [31:0] id);
    logic [31:0] a, m, d;
    a = {m_acc[0], m_acc[1], m_acc[2], m_acc[3]};
    m = {m_msk[0], m_msk[1], m_msk[2], m_msk[3]};
    d = (id ^ a) & ~m;
    return id[19] ? (d == 0) : (d[31:16] == 0);
  endfunction

  task automatic wr(input int addr, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(addr); reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (addr < 4) m_acc[addr] = v; else m_msk[addr-4] = v;
  endtask

  task automatic set_filter(input logic [31:0] a, input logic [31:0] m);
    for (int i = 0; i < 4; i++) begin
      wr(i, a[31-8*i -: 8]);
      wr(i + 4, m[31-8*i -: 8]);
    end
  endtask

  task automatic check_fg(input string req);
    chk(rx_full == e_full, req, 64'(rx_full), 64'(e_full));
    chk(rx_irq == e_full, req, 64'(rx_irq), 64'(e_full));
    chk(overrun == e_ovr, req, 64'(overrun), 64'(e_ovr));
    chk(fg_id == e_fg, req, 64'(fg_id), 64'(e_fg));
    chk(fg_len == e_len && fg_data == e_data, req, fg_data, e_data);
  endtask

  task automatic send(input logic [31:0] id, input bit rel, input string req);
    logic [LW-1:0] ln;
    logic [DW-1:0] dt;
    bit h, was_full;
    ln = LW'($urandom_range(0, DB));
    dt = {$urandom, $urandom};
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_len = ln; frm_data = dt;
    @(negedge clk);
    frm_valid = 0; frm_id = $urandom; cpu_release = rel;
    chk(bg_id == id, "R1", 64'(bg_id), 64'(id));
    @(negedge clk);
    cpu_release = 0;
    h = model_hit(id);
    was_full = e_full;
    if (h && (!was_full || rel)) begin
      e_fg = id; e_len = ln; e_data = dt; e_full = 1;
    end else if (rel) e_full = 0;
    if (h && was_full && !rel) e_ovr = 1;
    check_fg(req);
  endtask

  task automatic release_fg();
    @(negedge clk); cpu_release = 1;
    @(negedge clk); cpu_release = 0; e_full = 0;
    chk(rx_full == 0, "R7", 64'(rx_full), 0);
  endtask

  task automatic clear_ovr();
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0; e_ovr = 0;
    chk(overrun == 0, "R8", 64'(overrun), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hang expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] base, flip;
    void'($urandom(32'd5150));
    for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_msk[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(rx_full == 0 && overrun == 0 && rx_irq == 0, "R9", 64'({rx_full, overrun}), 0);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk(reg_rdata == 0, "R9", 64'(reg_rdata), 0);
    end
    for (int a = 0; a < 8; a++) wr(a, 8'(8'h31 * (a + 1)));
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk(reg_rdata == 8'(8'h31 * (a + 1)), "R9", 64'(reg_rdata), 64'(8'h31 * (a + 1)));
    end
    // R3 exact extended match, then single-bit miss in byte 3
    set_filter(32'hA5_1C_3E_71, 32'h0);
    send(32'hA5_1C_3E_71, 0, "R3");
    release_fg();
    send(32'hA5_1C_3E_70, 0, "R3");
    chk(rx_full == 0, "R6", 64'(rx_full), 0);
    // R2 masked don't-care bit
    set_filter(32'hA5_1C_3E_71, 32'h00_00_00_01);
    send(32'hA5_1C_3E_70, 0, "R2");
    release_fg();
    send(32'hA4_1C_3E_70, 0, "R2");
    // R4 standard frame: bytes 2-3 ignored
    set_filter(32'h6B_40_99_99, 32'h00_07_00_00);
    send(32'h6B_45_12_34, 0, "R4");
    release_fg();
    send(32'h6B_C5_12_34, 0, "R4");
    // R8 overrun: second accepted frame while full
    set_filter(32'h0, 32'hFF_FF_FF_FF);
    send(32'h11_22_33_44, 0, "R5");
    send(32'h55_66_77_88, 0, "R8");
    chk(fg_id == 32'h11_22_33_44, "R8", 64'(fg_id), 64'h11223344);
    clear_ovr();
    // R7 release on the same edge as acceptance
    send(32'h99_AA_BB_CC, 1, "R7");
    chk(rx_full == 1 && fg_id == 32'h99_AA_BB_CC, "R7", 64'(fg_id), 64'h99AABBCC);
    release_fg();
    // R6 rejected frame does not disturb a held frame
    set_filter(32'h12_08_00_00, 32'h00_00_00_00);
    send(32'h12_08_00_00, 0, "R5");
    send(32'h13_08_00_00, 0, "R6");
    release_fg();
    // random mix
    base = 32'hC3_5A_0F_E1;
    set_filter(base, 32'h00_07_00_00);
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 19) == 0) begin
        base = $urandom;
        set_filter(base, $urandom & $urandom & $urandom);
      end
      flip = $urandom & $urandom & $urandom & $urandom;
      send(base ^ flip, $urandom_range(0, 3) == 0, "R5");
      if ($urandom_range(0, 5) == 0) release_fg();
      if ($urandom_range(0, 7) == 0) clear_ovr();
    end
    finish_run();
  end
endmodule